// File: doc/BRIEF.md
# Power Switchover Time Stamp Capture

This block records the calendar time at the moments the supply moves between main power and the backup battery. It watches a supply-good level, which analog logic outside the block has already debounced and decided. It also watches the packed time/date vector that the clock core presents. When main power drops, it latches the time into a to-battery stamp. When main power comes back, it latches the time into a to-main stamp.

Across a series of outages the two stamps behave differently. The to-battery stamp keeps the first drop and ignores later ones until software clears it. The to-main stamp is overwritten on every restore, so it always shows the most recent one. A host reads both stamps, one byte at a time, through a small register port. The host also issues a clear strobe that zeroes both stamps and re-arms first-drop capture. The port and the strobe are honoured only while main power is present.

A three-state power FSM tracks the supply. PWR_INIT is the reset state. It leaves on T_BOOT_MAIN (supply good) or T_BOOT_BATT (supply not good), and neither of these transitions captures a stamp. PWR_MAIN goes to PWR_BATT on T_DROP, which raises the to-battery capture event. PWR_BATT goes back to PWR_MAIN on T_RESTORE, which raises the to-main capture event.

Top module: `ts_switchover_stamp`

## Requirements
- R1: After reset both stamps read as zero, the status word reads zero, and rd_valid is low.
- R2: On the clock edge where main_ok is first seen low while in PWR_MAIN, now_time is latched into the to-battery stamp and status bit 0 (to-battery held) is set.
- R3: While status bit 0 is set, further drops leave the to-battery stamp unchanged.
- R4: On each clock edge where main_ok is first seen high while in PWR_BATT, now_time is latched into the to-main stamp, replacing any earlier value, and status bit 1 (to-main held) is set.
- R5: A clr_req pulse while main_ok is high zeroes both stamps and both status bits, and the next drop is captured again.
- R6: When clr_req and a restore fall in the same cycle, the to-main stamp takes the new time and status bit 1 is set, while the to-battery stamp and status bit 0 are cleared.
- R7: A read with rd_en high and main_ok high returns data with rd_valid high one cycle later. Addresses 0 to 5 hold to-battery bytes and 6 to 11 hold to-main bytes, in both cases with byte 0 = time bits 7:0. Address 12 is the status word (bit 0 to-battery held, bit 1 to-main held). Higher addresses return zero.
- R8: While main_ok is low, rd_en produces no rd_valid and clr_req has no effect on either stamp.
- R9: Leaving reset captures nothing, whatever the level of main_ok. A restore that follows a boot into PWR_BATT fills only the to-main stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_ok | input | 1 | Main supply good, already debounced |
| now_time | input | TIME_W | Packed current time/date from the clock core |
| clr_req | input | 1 | Host strobe that clears both stamps |
| rd_en | input | 1 | Host read request |
| rd_addr | input | clog2(2*TIME_W/DW+1) | Host read byte address |
| rd_data | output | DW | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe, one cycle after rd_en |

## Verification
The host clear and the restore-to-main capture can land in the same clock edge. The clear can only act while the supply is good, and the restore is exactly the edge at which the supply becomes good. The bench raises main_ok and asserts clr_req on the same falling edge, with a fresh time value on now_time. It then reads back both stamps and the status word. It expects the new time in the to-main stamp and zeros in the to-battery stamp, with only status bit 1 set.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic [1:0] {
        PWR_INIT = 2'd0,
        PWR_MAIN = 2'd1,
        PWR_BATT = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/ts_power_fsm.sv
module ts_power_fsm
    import ts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_ok,
    output logic cap_to_batt,
    output logic cap_to_main
);
    pwr_state_t state_q;
    pwr_state_t state_d;

    // next-state selection: T_BOOT_MAIN, T_BOOT_BATT, T_DROP, T_RESTORE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_INIT: state_d = main_ok ? PWR_MAIN : PWR_BATT;
            PWR_MAIN: if (!main_ok) state_d = PWR_BATT;
            PWR_BATT: if (main_ok) state_d = PWR_MAIN;
            default:  state_d = PWR_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_INIT;
        else        state_q <= state_d;
    end

    // outputs: capture events, none on the boot transitions
    always_comb begin
        cap_to_batt = 1'b0;
        cap_to_main = 1'b0;
        unique case (state_q)
            PWR_INIT: ;
            PWR_MAIN: cap_to_batt = !main_ok;
            PWR_BATT: cap_to_main = main_ok;
            default:  ;
        endcase
    end
endmodule

// File: rtl/ts_capture_reg.sv
module ts_capture_reg #(
    parameter int TIME_W     = 48,
    parameter bit KEEP_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_ev,
    input  logic              clr,
    input  logic [TIME_W-1:0] now_time,
    output logic [TIME_W-1:0] ts_q,
    output logic              held_q
);
    logic take;

    generate
        if (KEEP_FIRST) begin : g_first
            // a clear in the same cycle re-arms, so the new event is taken
            assign take = cap_ev && (!held_q || clr);
        end else begin : g_last
            assign take = cap_ev;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q   <= '0;
            held_q <= 1'b0;
        end else if (take) begin
            ts_q   <= now_time;
            held_q <= 1'b1;
        end else if (clr) begin
            ts_q   <= '0;
            held_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ts_read_port.sv
module ts_read_port #(
    parameter int TIME_W = 48,
    parameter int DW     = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_ok,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [TIME_W-1:0] ts_bat,
    input  logic [TIME_W-1:0] ts_main,
    input  logic              bat_held,
    input  logic              main_held,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid
);
    localparam int NB = TIME_W / DW;
    localparam int NW = 2 * NB + 1;

    logic [DW-1:0] words [NW];
    logic [DW-1:0] sel;
    logic          serve;

    generate
        for (genvar i = 0; i < NB; i++) begin : g_bytes
            assign words[i]      = ts_bat[i*DW +: DW];
            assign words[NB + i] = ts_main[i*DW +: DW];
        end
    endgenerate
    assign words[2*NB] = {{(DW-2){1'b0}}, main_held, bat_held};

    assign serve = rd_en && main_ok;

    always_comb begin
        sel = '0;
        if (int'(rd_addr) < NW) sel = words[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= serve;
            rd_data  <= serve ? sel : '0;
        end
    end
endmodule

// File: rtl/ts_switchover_stamp.sv
module ts_switchover_stamp #(
    parameter int TIME_W = 48,
    parameter int DW     = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                main_ok,
    input  logic [TIME_W-1:0]                   now_time,
    input  logic                                clr_req,
    input  logic                                rd_en,
    input  logic [$clog2(2*(TIME_W/DW)+1)-1:0]  rd_addr,
    output logic [DW-1:0]                       rd_data,
    output logic                                rd_valid
);
    localparam int AW = $clog2(2*(TIME_W/DW)+1);

    logic              cap_to_batt;
    logic              cap_to_main;
    logic              clr_eff;
    logic              bat_held;
    logic              main_held;
    logic [TIME_W-1:0] ts_bat;
    logic [TIME_W-1:0] ts_main;

    // host strobe honoured only with main power present
    assign clr_eff = clr_req && main_ok;

    ts_power_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_ok     (main_ok),
        .cap_to_batt (cap_to_batt),
        .cap_to_main (cap_to_main)
    );

    ts_capture_reg #(.TIME_W(TIME_W), .KEEP_FIRST(1'b1)) u_bat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_ev   (cap_to_batt),
        .clr      (clr_eff),
        .now_time (now_time),
        .ts_q     (ts_bat),
        .held_q   (bat_held)
    );

    ts_capture_reg #(.TIME_W(TIME_W), .KEEP_FIRST(1'b0)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_ev   (cap_to_main),
        .clr      (clr_eff),
        .now_time (now_time),
        .ts_q     (ts_main),
        .held_q   (main_held)
    );

    ts_read_port #(.TIME_W(TIME_W), .DW(DW), .AW(AW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_ok   (main_ok),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .ts_bat    (ts_bat),
        .ts_main   (ts_main),
        .bat_held  (bat_held),
        .main_held (main_held),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );
endmodule

// File: rtl/ts_switchover_stamp_chk.sv
module ts_switchover_stamp_chk #(
    parameter int TIME_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              main_ok,
    input logic              clr_req,
    input logic              rd_valid,
    input logic [TIME_W-1:0] now_time,
    input logic              cap_to_batt,
    input logic              cap_to_main,
    input logic [TIME_W-1:0] ts_bat,
    input logic [TIME_W-1:0] ts_main,
    input logic              bat_held
);
    // R2
    first_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_to_batt && !bat_held) |=> (bat_held && ts_bat == $past(now_time)));

    // R3
    keep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_held && !(clr_req && main_ok)) |=> $stable(ts_bat));

    // R4
    latest_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_to_main |=> (ts_main == $past(now_time)));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && main_ok && !cap_to_batt && !cap_to_main)
        |=> (ts_bat == '0 && ts_main == '0 && !bat_held));

    // R8
    no_read_in_batt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_ok |=> !rd_valid);
endmodule

bind ts_switchover_stamp ts_switchover_stamp_chk #(.TIME_W(TIME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_ok     (main_ok),
    .clr_req     (clr_req),
    .rd_valid    (rd_valid),
    .now_time    (now_time),
    .cap_to_batt (cap_to_batt),
    .cap_to_main (cap_to_main),
    .ts_bat      (ts_bat),
    .ts_main     (ts_main),
    .bat_held    (bat_held)
);

// File: tb/ts_switchover_stamp_tb.sv
module ts_switchover_stamp_tb;
    localparam int TIME_W = 48;
    localparam int DW     = 8;
    localparam int NB     = TIME_W / DW;
    localparam int AW     = $clog2(2*NB+1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              main_ok = 1'b1;
    logic [TIME_W-1:0] now_time = '0;
    logic              clr_req = 1'b0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic              rd_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ts_switchover_stamp #(.TIME_W(TIME_W), .DW(DW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .main_ok  (main_ok),
        .now_time (now_time),
        .clr_req  (clr_req),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic do_reset(input logic supply);
        @(negedge clk);
        rst_n = 1'b0; main_ok = supply; clr_req = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_byte(input int a, output logic v, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic read_stamp(input int base, input string req, output logic [TIME_W-1:0] ts);
        logic v;
        logic [DW-1:0] d;
        ts = '0;
        for (int i = 0; i < NB; i++) begin
            read_byte(base + i, v, d);
            if (!v) check({req, " valid"}, 64'(v), 64'd1);
            ts[i*DW +: DW] = d;
        end
    endtask

    task automatic read_status(output logic [DW-1:0] s);
        logic v;
        read_byte(2*NB, v, s);
    endtask

    task automatic set_power(input logic supply, input logic [TIME_W-1:0] t);
        @(negedge clk);
        main_ok = supply; now_time = t;
        @(negedge clk);
        now_time = t ^ 48'hFFFF_0000_FFFF;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic [TIME_W-1:0] eb,
                             input logic [TIME_W-1:0] em, input logic [DW-1:0] es);
        logic [TIME_W-1:0] ts;
        logic [DW-1:0] s;
        read_stamp(0, req, ts);
        check({req, " to-battery"}, 64'(ts), 64'(eb));
        read_stamp(NB, req, ts);
        check({req, " to-main"}, 64'(ts), 64'(em));
        read_status(s);
        check({req, " status"}, 64'(s), 64'(es));
    endtask

    // R1
    task automatic t_reset();
        do_reset(1'b1);
        check("R1 rd_valid idle", 64'(rd_valid), 64'd0);
        check_all("R1", '0, '0, 8'h00);
    endtask

    // R2 R4
    task automatic t_first_outage();
        set_power(1'b0, 48'h24_03_15_08_30_11);
        set_power(1'b1, 48'h24_03_15_09_45_22);
        check_all("R2 R4", 48'h24_03_15_08_30_11, 48'h24_03_15_09_45_22, 8'h03);
    endtask

    // R3 R4
    task automatic t_second_outage();
        set_power(1'b0, 48'h24_04_01_10_00_33);
        set_power(1'b1, 48'h24_04_01_12_12_44);
        check_all("R3 R4", 48'h24_03_15_08_30_11, 48'h24_04_01_12_12_44, 8'h03);
    endtask

    // R8
    task automatic t_host_in_battery();
        logic v;
        logic [DW-1:0] d;
        set_power(1'b0, 48'h24_05_05_05_05_05);
        read_byte(0, v, d);
        check("R8 no read in battery", 64'(v), 64'd0);
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        set_power(1'b1, 48'h24_05_06_06_06_06);
        check_all("R8 clear ignored", 48'h24_03_15_08_30_11, 48'h24_05_06_06_06_06, 8'h03);
    endtask

    // R5
    task automatic t_clear();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        check_all("R5 cleared", '0, '0, 8'h00);
        set_power(1'b0, 48'h24_06_10_01_02_03);
        set_power(1'b1, 48'h24_06_10_04_05_06);
        check_all("R5 re-armed", 48'h24_06_10_01_02_03, 48'h24_06_10_04_05_06, 8'h03);
    endtask

    // R6
    task automatic t_collision();
        set_power(1'b0, 48'h24_07_07_07_07_07);
        @(negedge clk);
        main_ok = 1'b1; clr_req = 1'b1; now_time = 48'h24_07_08_11_22_33;
        @(negedge clk);
        clr_req = 1'b0; now_time = '0;
        repeat (2) @(negedge clk);
        check_all("R6 clear+restore", '0, 48'h24_07_08_11_22_33, 8'h02);
    endtask

    // R7
    task automatic t_address_map();
        logic v;
        logic [DW-1:0] d;
        read_byte(NB, v, d);
        check("R7 to-main byte0 valid", 64'(v), 64'd1);
        check("R7 to-main byte0", 64'(d), 64'h33);
        read_byte(2*NB - 1, v, d);
        check("R7 to-main byte5", 64'(d), 64'h24);
        for (int a = 2*NB + 1; a < (1 << AW); a++) begin
            read_byte(a, v, d);
            check("R7 unmapped valid", 64'(v), 64'd1);
            check("R7 unmapped zero", 64'(d), 64'd0);
        end
    endtask

    // R9
    task automatic t_boot_battery();
        now_time = 48'h11_11_11_11_11_11;
        do_reset(1'b0);
        set_power(1'b1, 48'h25_01_01_00_00_01);
        check_all("R9 boot in battery", '0, 48'h25_01_01_00_00_01, 8'h02);
    endtask

    initial begin
        t_reset();
        t_first_outage();
        t_second_outage();
        t_host_in_battery();
        t_clear();
        t_collision();
        t_address_map();
        t_boot_battery();
        summary();
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule